// File: doc/BRIEF.md
# I2C Receive Interrupt and Clock-Hold Sequencer

This block sits beside the receive shifter of a multi-master I2C port and decides when software is interrupted during a byte. It synchronizes the raw SCL and SDA lines and recognizes START and STOP conditions. It counts the data-bit clocks of each byte, raises a one-cycle interrupt pulse, clears an active-low pending bit and holds SCL low until software restarts the bus.

Two request points exist for each byte. The late point is the falling edge of the acknowledge clock. The early point is the falling edge of the last data-bit clock. The early point applies only when three things are true: the early enable is set, an internal wait flag is set, and the byte is not the address byte that follows a START. A write to the data register sets the wait flag and a write to the control register clears it, so software chooses the point again for every byte. After an early stop, software writes the acknowledge value through the control register and then releases the pending bit. The acknowledge clock then runs and a second request follows at its falling edge. When the acknowledge clock is disabled, the only request comes at the falling edge of the last data clock. A separate enable lets a STOP condition raise a pulse without touching the pending bit.

The controller has six states. ST_IDLE waits for a START. ST_DATA counts data clocks. ST_HOLD_EARLY holds the bus after the last data bit. ST_ACK_SLOT is the acknowledge bit period. ST_HOLD_ACK holds the bus after the acknowledge clock. ST_HOLD_BYTE holds the bus after a byte that has no acknowledge clock. The transitions are as follows:
- Any state goes to ST_IDLE on a STOP, and to ST_DATA on a START.
- ST_DATA goes to ST_HOLD_EARLY, ST_ACK_SLOT or ST_HOLD_BYTE on the last data-clock fall.
- ST_HOLD_EARLY goes to ST_ACK_SLOT when the pending bit is written.
- ST_ACK_SLOT goes to ST_HOLD_ACK on the acknowledge-clock fall.
- ST_HOLD_ACK and ST_HOLD_BYTE return to ST_DATA when the pending bit is written.

Top module: `i2c_rx_irq_ctrl`

## Requirements
- R1: `wait_flag` reads as `early_en` AND the internal wait flag AND NOT the address-byte marker. The internal wait flag is set by a `data_wr` pulse and cleared by a `ctrl_wr` pulse. When both pulses arrive in the same cycle, the flag is cleared.
- R2: Early request. The acknowledge clock is enabled, `early_en` is 1, the wait flag is set and the byte is not an address byte. On the falling SCL edge that ends the 8th data bit, `irq` pulses, `pend_n` goes to 0 and `scl_hold` goes to 1.
- R3: One clock after `pend_wr` is sampled during a hold, `scl_hold` is 0 and `pend_n` is 1.
- R4: With the acknowledge clock enabled, the falling SCL edge that ends the 9th (acknowledge) clock always pulses `irq`, clears `pend_n` and sets `scl_hold`. This includes the byte that follows an early restart.
- R5: After a START, the first byte never takes the early request, whatever `early_en` and the wait flag are. `wait_flag` reads 0 during that byte.
- R6: With the acknowledge clock disabled (`ctrl_ackclk`=0 at the last control write), the request comes on the 8th data-clock fall and the bus is held.
- R7: A STOP (SDA rising while SCL is high) pulses `irq` only when `stop_en` is 1, and leaves `pend_n` unchanged.
- R8: `irq` is a single-cycle pulse, and exactly one pulse is issued per request.
- R9: During the acknowledge bit period, `sda_pull` is 1 when the acknowledge bit stored from `ctrl_ack` is 0, and 0 when it is 1. No pull is driven while in the early hold.
- R10: After reset, `pend_n`=1, `scl_hold`=0, `irq`=0, `sda_pull`=0 and `wait_flag`=0.
- R11: A START, including a repeated START in the middle of a byte, restarts the bit count. No request is raised before the 8th data-clock fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| data_wr | input | 1 | Data register write strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_ack | input | 1 | Acknowledge bit written with `ctrl_wr` (0 = drive ACK) |
| ctrl_ackclk | input | 1 | Acknowledge-clock enable written with `ctrl_wr` |
| early_en | input | 1 | Enable for the request after the last data bit |
| stop_en | input | 1 | Enable for the request on a STOP condition |
| pend_wr | input | 1 | Write of 1 to the pending bit (restart) |
| scl_hold | output | 1 | Drive SCL low |
| sda_pull | output | 1 | Drive SDA low for the acknowledge |
| irq | output | 1 | Interrupt request pulse |
| pend_n | output | 1 | Pending bit, active low |
| wait_flag | output | 1 | Readable effective wait flag |

## Verification
A change on either bus line reaches the registered outputs on the third rising clock edge after it is driven: two synchronizer stages, one history stage and then the state register. So `irq`, `pend_n`, `scl_hold` and `sda_pull` are sampled at the falling edge that follows that third rising edge, and the single-cycle pulse is caught in the only cycle where it is high. A `pend_wr` or register strobe acts at the next rising edge, so release and flag checks are taken one falling edge after the strobe is removed. A running count of observed pulses is compared at the end with the count the bench model predicts, which exposes extra or missing pulses between sample points.

// File: rtl/i2c_rxirq_pkg.sv
package i2c_rxirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_DATA       = 3'd1,
        ST_HOLD_EARLY = 3'd2,
        ST_ACK_SLOT   = 3'd3,
        ST_HOLD_ACK   = 3'd4,
        ST_HOLD_BYTE  = 3'd5
    } rx_state_t;

    function automatic logic is_hold(input rx_state_t s);
        return (s == ST_HOLD_EARLY) || (s == ST_HOLD_ACK) || (s == ST_HOLD_BYTE);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    localparam int DEPTH = STAGES + 1;

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [DEPTH-1:0] shreg;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '1;
                else        shreg <= {shreg[DEPTH-2:0], raw[g]};
            end
            assign level[g] = shreg[DEPTH-2];
            assign rise[g]  = shreg[DEPTH-2] & ~shreg[DEPTH-1];
            assign fall[g]  = ~shreg[DEPTH-2] & shreg[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/i2c_bit_counter.sv
module i2c_bit_counter #(
    parameter int DATA_BITS = 8,
    localparam int CW = $clog2(DATA_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          last_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc && (cnt != CW'(DATA_BITS))) cnt <= cnt + 1'b1;
    end

    assign last_data = (cnt == CW'(DATA_BITS));
endmodule

// File: rtl/i2c_rxirq_regs.sv
module i2c_rxirq_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic data_wr,
    input  logic ctrl_wr,
    input  logic ctrl_ack,
    input  logic ctrl_ackclk,
    output logic ack_q,
    output logic ackclk_q,
    output logic wait_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q    <= 1'b1;
            ackclk_q <= 1'b1;
        end else if (ctrl_wr) begin
            ack_q    <= ctrl_ack;
            ackclk_q <= ctrl_ackclk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wait_q <= 1'b0;
        else if (ctrl_wr) wait_q <= 1'b0;
        else if (data_wr) wait_q <= 1'b1;
    end

    AST_WAIT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !wait_q); // R1
    AST_WAIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !ctrl_wr) |=> wait_q); // R1
endmodule

// File: rtl/i2c_rxirq_fsm.sv
module i2c_rxirq_fsm
    import i2c_rxirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic sda_rise,
    input  logic sda_fall,
    input  logic last_data,
    input  logic ack_q,
    input  logic ackclk_q,
    input  logic wait_q,
    input  logic early_en,
    input  logic stop_en,
    input  logic pend_wr,
    output logic cnt_inc,
    output logic cnt_clr,
    output logic addr_q,
    output logic irq,
    output logic pend_n,
    output logic scl_hold,
    output logic sda_pull
);
    rx_state_t st, nxt;
    logic start_det, stop_det, early_go, req_byte;

    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;
    assign early_go  = early_en & wait_q & ~addr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt     = st;
        cnt_inc = 1'b0;
        cnt_clr = 1'b0;
        if (stop_det) begin
            nxt     = ST_IDLE;
            cnt_clr = 1'b1;
        end else if (start_det) begin
            nxt     = ST_DATA;
            cnt_clr = 1'b1;
        end else begin
            unique case (st)
                ST_IDLE: nxt = ST_IDLE;
                ST_DATA: begin
                    cnt_inc = scl_rise;
                    if (scl_fall && last_data) begin
                        if (!ackclk_q) begin
                            nxt     = ST_HOLD_BYTE;
                            cnt_clr = 1'b1;
                        end else if (early_go) begin
                            nxt = ST_HOLD_EARLY;
                        end else begin
                            nxt = ST_ACK_SLOT;
                        end
                    end
                end
                ST_HOLD_EARLY: if (pend_wr) nxt = ST_ACK_SLOT;
                ST_ACK_SLOT: begin
                    if (scl_fall) begin
                        nxt     = ST_HOLD_ACK;
                        cnt_clr = 1'b1;
                    end
                end
                ST_HOLD_ACK:  if (pend_wr) nxt = ST_DATA;
                ST_HOLD_BYTE: if (pend_wr) nxt = ST_DATA;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    assign req_byte = (nxt != st) && is_hold(nxt) && !stop_det && !start_det;

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            pend_n   <= 1'b1;
            scl_hold <= 1'b0;
            sda_pull <= 1'b0;
            addr_q   <= 1'b0;
        end else begin
            irq      <= req_byte | (stop_det & stop_en);
            scl_hold <= is_hold(nxt);
            sda_pull <= (nxt == ST_ACK_SLOT) & ~ack_q;
            if (req_byte)     pend_n <= 1'b0;
            else if (pend_wr) pend_n <= 1'b1;
            if (start_det)                               addr_q <= 1'b1;
            else if (req_byte && nxt != ST_HOLD_EARLY)   addr_q <= 1'b0;
        end
    end

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8
    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold && pend_wr) |=> (!scl_hold && pend_n)); // R3
    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> !pend_n); // R2
    AST_NO_EARLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD_EARLY) |-> !addr_q); // R5
    AST_EARLY_NEEDS_ACKCLK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD_EARLY) |-> ackclk_q); // R6
    AST_NO_PULL_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> !sda_pull); // R9
endmodule

// File: rtl/i2c_rx_irq_ctrl.sv
module i2c_rx_irq_ctrl #(
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(DATA_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic data_wr,
    input  logic ctrl_wr,
    input  logic ctrl_ack,
    input  logic ctrl_ackclk,
    input  logic early_en,
    input  logic stop_en,
    input  logic pend_wr,
    output logic scl_hold,
    output logic sda_pull,
    output logic irq,
    output logic pend_n,
    output logic wait_flag
);
    localparam int SCL_IDX = 0;
    localparam int SDA_IDX = 1;

    logic [1:0] lvl, rise, fall;
    logic [CW-1:0] cnt;
    logic last_data, cnt_inc, cnt_clr;
    logic ack_q, ackclk_q, wait_q, addr_q;

    i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({sda_in, scl_in}),
        .level(lvl), .rise(rise), .fall(fall)
    );

    i2c_bit_counter #(.DATA_BITS(DATA_BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .cnt(cnt), .last_data(last_data)
    );

    i2c_rxirq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
        .ctrl_ack(ctrl_ack), .ctrl_ackclk(ctrl_ackclk),
        .ack_q(ack_q), .ackclk_q(ackclk_q), .wait_q(wait_q)
    );

    i2c_rxirq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(lvl[SCL_IDX]), .scl_rise(rise[SCL_IDX]), .scl_fall(fall[SCL_IDX]),
        .sda_rise(rise[SDA_IDX]), .sda_fall(fall[SDA_IDX]),
        .last_data(last_data), .ack_q(ack_q), .ackclk_q(ackclk_q), .wait_q(wait_q),
        .early_en(early_en), .stop_en(stop_en), .pend_wr(pend_wr),
        .cnt_inc(cnt_inc), .cnt_clr(cnt_clr), .addr_q(addr_q),
        .irq(irq), .pend_n(pend_n), .scl_hold(scl_hold), .sda_pull(sda_pull)
    );

    assign wait_flag = early_en & wait_q & ~addr_q;

    AST_BIT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DATA_BITS)); // R11
endmodule

// File: tb/tb_i2c_rx_irq_ctrl.sv
module tb_i2c_rx_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic data_wr = 1'b0, ctrl_wr = 1'b0, ctrl_ack = 1'b1, ctrl_ackclk = 1'b1;
    logic early_en = 1'b0, stop_en = 1'b0, pend_wr = 1'b0;
    logic scl_hold, sda_pull, irq, pend_n, wait_flag;
    logic scl_in, sda_in;

    int checks = 0, errors = 0, exp_irq = 0, irq_seen = 0;
    bit m_wait = 0, m_addr = 0, m_ack = 1, m_ackclk = 1, done = 0;

    always #5 clk = ~clk;

    assign scl_in = scl_m & ~scl_hold;
    assign sda_in = sda_m & ~sda_pull;

    i2c_rx_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .data_wr(data_wr), .ctrl_wr(ctrl_wr), .ctrl_ack(ctrl_ack),
        .ctrl_ackclk(ctrl_ackclk), .early_en(early_en), .stop_en(stop_en),
        .pend_wr(pend_wr), .scl_hold(scl_hold), .sda_pull(sda_pull),
        .irq(irq), .pend_n(pend_n), .wait_flag(wait_flag)
    );

    always @(negedge clk) if (rst_n && irq) irq_seen++;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_flag();
        return int'(early_en & m_wait & !m_addr);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle3();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic w_data();
        @(negedge clk) data_wr = 1'b1;
        @(negedge clk) data_wr = 1'b0;
        m_wait = 1;
        check("R1 wait flag after data write", wait_flag, exp_flag());
    endtask

    task automatic w_ctrl(input bit a, input bit ac);
        @(negedge clk);
        ctrl_ack = a; ctrl_ackclk = ac; ctrl_wr = 1'b1;
        @(negedge clk) ctrl_wr = 1'b0;
        m_wait = 0; m_ack = a; m_ackclk = ac;
        check("R1 wait flag after control write", wait_flag, 0);
    endtask

    task automatic release_hold();
        @(negedge clk) pend_wr = 1'b1;
        @(negedge clk) pend_wr = 1'b0;
        check("R3 hold released", scl_hold, 0);
        check("R3 pending cleared", pend_n, 1);
    endtask

    task automatic scl_high();
        while (scl_hold) @(negedge clk);
        scl_m = 1'b1;
        cyc(4);
    endtask

    task automatic do_start();
        if (!scl_m) begin
            sda_m = 1'b1; cyc(2); scl_high();
        end
        sda_m = 1'b0;
        settle3();
        m_addr = 1;
        check("R11 no request on START", irq, 0);
        check("R5 wait flag reads 0 in address byte", wait_flag, 0);
        cyc(1);
        scl_m = 1'b0;
        cyc(3);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; cyc(2);
        scl_high();
        sda_m = 1'b1;
        settle3();
        check("R7 stop request", irq, int'(stop_en));
        check("R7 pending unchanged by stop", pend_n, 1);
        if (stop_en) exp_irq++;
        cyc(3);
    endtask

    task automatic send_byte(input bit [7:0] v);
        bit early, req8;
        string tag;
        for (int i = 7; i >= 0; i--) begin
            sda_m = v[i]; cyc(2);
            scl_high();
            scl_m = 1'b0;
            settle3();
            if (i > 0) check("R11 no request before last data bit", irq, 0);
        end
        early = m_ackclk & early_en & m_wait & !m_addr;
        req8  = !m_ackclk | early;
        tag = !m_ackclk ? "R6 no-ack byte request" : (m_addr ? "R5 address byte late only" : "R2 early request");
        check(tag, irq, int'(req8));
        check(tag, pend_n, int'(!req8));
        check(tag, scl_hold, int'(req8));
        if (req8) exp_irq++;
        sda_m = 1'b1;
        if (!m_ackclk) begin
            cyc(2); release_hold(); m_addr = 0;
        end else begin
            if (early) begin
                cyc(2);
                w_ctrl(1'($urandom_range(0, 1)), 1'b1);
                release_hold();
            end
            check("R9 ack pull level", sda_pull, int'(!m_ack));
            cyc(2);
            scl_high();
            scl_m = 1'b0;
            settle3();
            check("R4 ack clock request", irq, 1);
            check("R4 pending after ack clock", pend_n, 0);
            check("R4 hold after ack clock", scl_hold, 1);
            check("R9 pull released after ack", sda_pull, 0);
            exp_irq++;
            m_addr = 0;
            cyc(2);
            release_hold();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        // R10 reset state
        check("R10 pend_n", pend_n, 1);
        check("R10 scl_hold", scl_hold, 0);
        check("R10 irq", irq, 0);
        check("R10 sda_pull", sda_pull, 0);
        check("R10 wait_flag", wait_flag, 0);

        // directed: early path, repeated START mid-byte
        w_ctrl(1'b0, 1'b1);
        early_en = 1'b1; stop_en = 1'b1;
        w_data();
        do_start();
        for (int k = 0; k < 3; k++) begin
            sda_m = 1'b1; cyc(2); scl_high(); scl_m = 1'b0; cyc(3);
        end
        do_start();
        send_byte(8'hA4);
        send_byte(8'h3C);
        do_stop();

        // R1 simultaneous writes leave the flag clear
        @(negedge clk);
        ctrl_ack = 1'b0; ctrl_ackclk = 1'b1; data_wr = 1'b1; ctrl_wr = 1'b1;
        @(negedge clk) begin data_wr = 1'b0; ctrl_wr = 1'b0; end
        m_wait = 0; m_ack = 0; m_ackclk = 1;
        check("R1 simultaneous writes", wait_flag, 0);

        // directed: no acknowledge clock, stop request disabled
        w_ctrl(1'b1, 1'b0);
        early_en = 1'b0; stop_en = 1'b0;
        do_start();
        send_byte(8'h51);
        send_byte(8'hE7);
        do_stop();

        // constrained random transfers
        for (int t = 0; t < 25; t++) begin
            bit ac;
            int nb;
            ac = 1'($urandom_range(0, 1));
            w_ctrl(1'($urandom_range(0, 1)), ac);
            early_en = ac ? 1'($urandom_range(0, 1)) : 1'b0;
            stop_en  = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 1) == 1) w_data();
            do_start();
            send_byte(8'($urandom));
            nb = $urandom_range(1, 3);
            for (int b = 0; b < nb; b++) begin
                if ($urandom_range(0, 2) != 0) w_data();
                send_byte(8'($urandom));
            end
            do_stop();
        end

        cyc(5);
        check("R8 total request pulses", irq_seen, exp_irq);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule